// File: doc/BRIEF.md
# Shift and Rotate Unit with Flags

This unit performs the eight classic shift and rotate operations on a byte, word or doubleword operand. A caller supplies the operand, a width select, a 3-bit operation code, a count, the incoming carry, and two timing qualifiers in the same cycle as a one-cycle `start` pulse. One clock later, `done` pulses and the registered result, flags and cycle cost appear on the outputs.

Rotates go around the operand itself or through the carry. Rotate-through-carry treats the carry and the operand as a ring that is one bit wider than the operand. Plain shifts also set zero, sign and parity. A count that masks to zero leaves the result equal to the operand and changes no flag. The reported cost models the latency of the operation. It depends on the operation class, on whether the operand is in memory, and on an optional slow-timing mode.

Top module: `shrot_unit`

## Requirements
- R1: `op_sel` picks the operation: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 and 6 shift left, 5 logical shift right, 7 arithmetic shift right.
- R2: Only bits [4:0] of `shift_cnt` are used, so the effective count is 0..31 for every width, and bits [7:5] have no effect.
- R3: When the effective count is zero, `result` is the operand truncated to the selected width and `flags_valid` stays low. `carry_out`, `ovf_out`, `zero_out`, `sign_out` and `parity_out` keep their previous values, and `cost` reads 0.
- R4: Rotate left: `carry_out` equals result bit 0, and `ovf_out` is `carry_out` XOR the result MSB.
- R5: Rotate right: `carry_out` equals the result MSB, and `ovf_out` is the XOR of the two top result bits.
- R6: Rotate through carry moves a ring of width+1 bits formed by `carry_in` above the operand, one position per count step. Counts above the width wrap around this ring, and the new carry is the top ring bit. Overflow follows R4 for left and R5 for right.
- R7: Shift left and logical shift right fill with zeros, and arithmetic shift right fills with the sign bit. The result is truncated to the width. `carry_out` is the last bit shifted out, which is 0 for counts beyond the width in the logical shifts and the sign in the arithmetic one.
- R8: For plain shifts, `ovf_out` is defined only for a count of 1: for shift left it is the result MSB XOR `carry_out`, for logical right it is the original MSB, and for arithmetic right it is 0. For any other count it is 0.
- R9: For plain shifts with a nonzero count, `zero_out` is set when the result is 0, `sign_out` equals the result MSB, and `parity_out` is 1 when the low result byte holds an even number of ones. Rotates leave these three flags unchanged.
- R10: `cost` is 3 for a register operand and 7 for a memory operand on rotate left or right and on plain shifts. It is 9 and 10 respectively on the through-carry rotates.
- R11: With `slow_timing` high, the effective count is added to the cost of the through-carry rotates only.
- R12: `done` is high exactly in the cycle after each `start`. `flags_valid` is high with it whenever the count is nonzero. After reset, all outputs are 0.
- R13: `size_sel` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; all other inputs sampled with it |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Operand width select |
| shift_cnt | input | 8 | Count; low 5 bits used |
| operand | input | 32 | Data to shift or rotate |
| carry_in | input | 1 | Incoming carry flag |
| mem_operand | input | 1 | Operand comes from memory (cost) |
| slow_timing | input | 1 | Add count to through-carry rotate cost |
| done | output | 1 | Result strobe, one cycle after start |
| flags_valid | output | 1 | Flags were updated by this operation |
| result | output | 32 | Shifted or rotated value, zero-extended |
| carry_out | output | 1 | New carry flag |
| ovf_out | output | 1 | New overflow flag |
| zero_out | output | 1 | Zero flag |
| sign_out | output | 1 | Sign flag |
| parity_out | output | 1 | Even-parity flag of low byte |
| cost | output | 6 | Modelled cycle cost |

## Verification
The assertions assume that `start` is a single-cycle pulse and that every request input is stable and known in the cycle where `start` is high. The zero-count checks also assume that nothing other than a request can move the flag registers. The directed tasks drive all request inputs together with `start` on the falling edge and drop `start` on the next falling edge. They leave a cycle between requests and drive every input to a defined value, so these assumptions always hold. The held-flag cases first create a known flag state with one request and then issue the request that must not disturb it.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 5;
    localparam int COST_W  = 6;
    localparam int LANE_N  = $clog2(DATA_W / 8) + 1;

    typedef enum logic [2:0] {
        OP_ROL  = 3'd0,
        OP_ROR  = 3'd1,
        OP_RCL  = 3'd2,
        OP_RCR  = 3'd3,
        OP_SHL  = 3'd4,
        OP_SHR  = 3'd5,
        OP_SHL2 = 3'd6,
        OP_SAR  = 3'd7
    } op_e;

    typedef struct packed {
        logic              done;
        logic              fv;
        logic [DATA_W-1:0] res;
        logic              cf;
        logic              of;
        logic              zf;
        logic              sf;
        logic              pf;
        logic [COST_W-1:0] cost;
    } unit_st_t;
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 5
) (
    input  logic [N-1:0]  x,
    input  logic          cin,
    input  logic [CW-1:0] cnt,
    input  op_e           op,
    output logic [N-1:0]  res,
    output logic          cf,
    output logic          of
);
    localparam int RW = N + 1;
    localparam int SW = N + (1 << CW);

    int unsigned     k_rot;
    int unsigned     k_ring;
    logic [2*N-1:0]  rl_w, rr_w;
    logic [2*RW-1:0] cl_w, cr_w;
    logic [RW-1:0]   ring_l, ring_r;
    logic [SW-1:0]   sl_w;
    logic [N:0]      sr_w;
    logic signed [N:0] sa_w;
    logic            one_step;

    always_comb begin
        k_rot   = int'(cnt) % N;
        k_ring  = int'(cnt) % RW;
        rl_w    = {x, x} << k_rot;
        rr_w    = {x, x} >> k_rot;
        cl_w    = {cin, x, cin, x} << k_ring;
        cr_w    = {cin, x, cin, x} >> k_ring;
        ring_l  = cl_w[2*RW-1:RW];
        ring_r  = cr_w[RW-1:0];
        sl_w    = {{(SW-N){1'b0}}, x} << cnt;
        sr_w    = {x, 1'b0} >> cnt;
        sa_w    = $signed({x, 1'b0}) >>> cnt;
        one_step = (cnt == CW'(1));

        res = x;
        cf  = 1'b0;
        of  = 1'b0;
        unique case (op)
            OP_ROL: begin
                res = rl_w[2*N-1:N];
                cf  = res[0];
                of  = res[0] ^ res[N-1];
            end
            OP_ROR: begin
                res = rr_w[N-1:0];
                cf  = res[N-1];
                of  = res[N-1] ^ res[N-2];
            end
            OP_RCL: begin
                res = ring_l[N-1:0];
                cf  = ring_l[N];
                of  = ring_l[N] ^ ring_l[N-1];
            end
            OP_RCR: begin
                res = ring_r[N-1:0];
                cf  = ring_r[N];
                of  = ring_r[N-1] ^ ring_r[N-2];
            end
            OP_SHL, OP_SHL2: begin
                res = sl_w[N-1:0];
                cf  = sl_w[N];
                of  = one_step & (sl_w[N-1] ^ sl_w[N]);
            end
            OP_SHR: begin
                res = sr_w[N:1];
                cf  = sr_w[0];
                of  = one_step & x[N-1];
            end
            OP_SAR: begin
                res = sa_w[N:1];
                cf  = sa_w[0];
                of  = 1'b0;
            end
            default: ;
        endcase
    end

    // Guards sit next to the lane datapath they check.
    always_comb begin
        if (op == OP_ROL || op == OP_ROR)
            a_r4_rotate_keeps_ones: assert ($countones(res) == $countones(x));
        if (op == OP_RCL || op == OP_RCR)
            a_r6_ring_keeps_ones: assert ($countones({cf, res}) == $countones({cin, x}));
        if (op == OP_SHR && cnt != '0)
            a_r7_shr_top_zero: assert (res[N-1] == 1'b0);
        if (op == OP_SAR)
            a_r8_sar_no_overflow: assert (of == 1'b0);
    end
endmodule

// File: rtl/shrot_cost.sv
module shrot_cost
    import shrot_pkg::*;
#(
    parameter int REG_FAST = 3,
    parameter int MEM_FAST = 7,
    parameter int REG_RING = 9,
    parameter int MEM_RING = 10
) (
    input  op_e               op,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              mem,
    input  logic              slow,
    output logic [COST_W-1:0] cost
);
    localparam int MAX_COST = MEM_RING + (1 << CNT_W) - 1;

    int   total;
    logic ring_op;

    always_comb begin
        ring_op = (op == OP_RCL) || (op == OP_RCR);
        if (cnt == '0) begin
            total = 0;
        end else if (ring_op) begin
            total = (mem ? MEM_RING : REG_RING) + (slow ? int'(cnt) : 0);
        end else begin
            total = mem ? MEM_FAST : REG_FAST;
        end
        cost = COST_W'(total);
    end

    always_comb begin
        a_r10_cost_in_range: assert (total <= MAX_COST && total < (1 << COST_W));
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic [7:0]        shift_cnt,
    input  logic [31:0]       operand,
    input  logic              carry_in,
    input  logic              mem_operand,
    input  logic              slow_timing,
    output logic              done,
    output logic              flags_valid,
    output logic [31:0]       result,
    output logic              carry_out,
    output logic              ovf_out,
    output logic              zero_out,
    output logic              sign_out,
    output logic              parity_out,
    output logic [5:0]        cost
);
    localparam int LAST_LANE = LANE_N - 1;

    op_e               op;
    logic [CNT_W-1:0]  cnt5;
    int unsigned       lane_sel;
    logic [DATA_W-1:0] lane_res [LANE_N];
    logic              lane_cf  [LANE_N];
    logic              lane_of  [LANE_N];
    logic [COST_W-1:0] cost_d;
    logic [DATA_W-1:0] held_d;
    unit_st_t          st_d, st_q;

    assign op   = op_e'(op_sel);
    assign cnt5 = shift_cnt[CNT_W-1:0];

    always_comb begin
        lane_sel = (int'(size_sel) > LAST_LANE) ? LAST_LANE : int'(size_sel);
    end

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] lr;
        shrot_lane #(.N(LW), .CW(CNT_W)) u_lane (
            .x   (operand[LW-1:0]),
            .cin (carry_in),
            .cnt (cnt5),
            .op  (op),
            .res (lr),
            .cf  (lane_cf[g]),
            .of  (lane_of[g])
        );
        assign lane_res[g] = DATA_W'(lr);
    end

    shrot_cost u_cost (
        .op   (op),
        .cnt  (cnt5),
        .mem  (mem_operand),
        .slow (slow_timing),
        .cost (cost_d)
    );

    always_comb begin
        unique case (lane_sel)
            0:       held_d = DATA_W'(operand[7:0]);
            1:       held_d = DATA_W'(operand[15:0]);
            default: held_d = operand;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        st_d.fv   = 1'b0;
        if (start) begin
            st_d.cost = cost_d;
            if (cnt5 == '0) begin
                st_d.res = held_d;
            end else begin
                st_d.res = lane_res[lane_sel];
                st_d.cf  = lane_cf[lane_sel];
                st_d.of  = lane_of[lane_sel];
                st_d.fv  = 1'b1;
                if (op_sel[2]) begin
                    st_d.zf = (lane_res[lane_sel] == '0);
                    st_d.sf = lane_res[lane_sel][(8 << lane_sel) - 1];
                    st_d.pf = ~^lane_res[lane_sel][7:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done        = st_q.done;
    assign flags_valid = st_q.fv;
    assign result      = st_q.res;
    assign carry_out   = st_q.cf;
    assign ovf_out     = st_q.of;
    assign zero_out    = st_q.zf;
    assign sign_out    = st_q.sf;
    assign parity_out  = st_q.pf;
    assign cost        = st_q.cost;

    a_r12_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    a_r12_valid_within_done: assert property (@(posedge clk) disable iff (!rst_n)
        flags_valid |-> done);
    a_r3_zero_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (start && shift_cnt[4:0] == 5'd0) |=>
            (!flags_valid && cost == '0 && $stable(carry_out) && $stable(ovf_out)
             && $stable(zero_out)));
    a_r2_high_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && shift_cnt[4:0] == 5'd0 && shift_cnt[7:5] != 3'd0) |=> !flags_valid);
    a_r9_rotate_keeps_zsp: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op_sel[2]) |=>
            ($stable(zero_out) && $stable(sign_out) && $stable(parity_out)));
    a_r13_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size_sel == 2'd0) |=> (result[31:8] == 24'd0));
endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic [7:0]  shift_cnt = '0;
    logic [31:0] operand = '0;
    logic        carry_in = 1'b0;
    logic        mem_operand = 1'b0;
    logic        slow_timing = 1'b0;
    logic        done, flags_valid, carry_out, ovf_out, zero_out, sign_out, parity_out;
    logic [31:0] result;
    logic [5:0]  cost;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    shrot_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .size_sel(size_sel),
        .shift_cnt(shift_cnt), .operand(operand), .carry_in(carry_in),
        .mem_operand(mem_operand), .slow_timing(slow_timing), .done(done),
        .flags_valid(flags_valid), .result(result), .carry_out(carry_out),
        .ovf_out(ovf_out), .zero_out(zero_out), .sign_out(sign_out),
        .parity_out(parity_out), .cost(cost)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic int width_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    // Step-by-step model written from the requirements.
    function automatic void model(input logic [2:0] op, input int n, input int cnt,
                                  input logic [31:0] x0, input logic cin,
                                  output logic [31:0] r, output logic c, output logic o);
        logic [31:0] mask;
        logic [31:0] x;
        logic t;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
        x = x0 & mask;
        c = cin;
        o = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            case (op)
                3'd0: begin c = x[n-1]; x = ((x << 1) | 32'(c)) & mask; end
                3'd1: begin c = x[0]; x = (x >> 1) | (32'(c) << (n-1)); end
                3'd2: begin t = x[n-1]; x = ((x << 1) | 32'(c)) & mask; c = t; end
                3'd3: begin t = x[0]; x = (x >> 1) | (32'(c) << (n-1)); c = t; end
                3'd4, 3'd6: begin c = x[n-1]; x = (x << 1) & mask; end
                3'd5: begin c = x[0]; x = x >> 1; end
                default: begin c = x[0]; x = (x >> 1) | (32'(x[n-1]) << (n-1)); end
            endcase
        end
        case (op)
            3'd0, 3'd2: o = c ^ x[n-1];
            3'd1, 3'd3: o = x[n-1] ^ x[n-2];
            3'd4, 3'd6: o = (cnt == 1) ? (x[n-1] ^ c) : 1'b0;
            3'd5:       o = (cnt == 1) ? x0[n-1] : 1'b0;
            default:    o = 1'b0;
        endcase
        r = x;
    endfunction

    function automatic int exp_cost(input logic [2:0] op, input int cnt,
                                    input logic mem, input logic slow);
        if (cnt == 0) return 0;
        if (op == 3'd2 || op == 3'd3) return (mem ? 10 : 9) + (slow ? cnt : 0);
        return mem ? 7 : 3;
    endfunction

    task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic [7:0] c8,
                         input logic [31:0] x, input logic cin, input logic mem,
                         input logic slow);
        @(negedge clk);
        op_sel = op; size_sel = sz; shift_cnt = c8; operand = x;
        carry_in = cin; mem_operand = mem; slow_timing = slow; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Issues one request with a nonzero effective count and checks every output.
    task automatic run_case(input string tag, input logic [2:0] op, input logic [1:0] sz,
                            input logic [7:0] c8, input logic [31:0] x, input logic cin,
                            input logic mem, input logic slow);
        logic [31:0] er;
        logic ec, eo;
        int n;
        n = width_of(sz);
        model(op, n, int'(c8[4:0]), x, cin, er, ec, eo);
        issue(op, sz, c8, x, cin, mem, slow);
        chk({tag, " result"}, result, er);
        chk({tag, " carry"}, 32'(carry_out), 32'(ec));
        chk({tag, " overflow"}, 32'(ovf_out), 32'(eo));
        chk({tag, " R12 done/valid"}, {30'd0, done, flags_valid}, 32'd3);
        chk({tag, " cost R10"}, 32'(cost), 32'(exp_cost(op, int'(c8[4:0]), mem, slow)));
        if (op[2]) begin
            chk({tag, " R9 zero"}, 32'(zero_out), 32'(er == 32'd0));
            chk({tag, " R9 sign"}, 32'(sign_out), 32'(er[n-1]));
            chk({tag, " R9 parity"}, 32'(parity_out), 32'(~^er[7:0]));
        end
    endtask

    task automatic t_reset();
        chk("R12 reset outputs", {result[23:0], done, flags_valid, carry_out, ovf_out,
                                  zero_out, sign_out, parity_out, 1'b0},
            32'd0);
        chk("R12 reset cost", 32'(cost), 32'd0);
    endtask

    task automatic t_rotate();
        run_case("R4 rol byte", 3'd0, 2'd0, 8'd3, 32'h0000_00B1, 1'b0, 1'b0, 1'b0);
        run_case("R4 rol dword", 3'd0, 2'd2, 8'd31, 32'h8000_0001, 1'b1, 1'b0, 1'b0);
        run_case("R4 rol word wrap", 3'd0, 2'd1, 8'd17, 32'h0000_C003, 1'b0, 1'b1, 1'b0);
        run_case("R5 ror byte", 3'd1, 2'd0, 8'd1, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
        run_case("R5 ror word", 3'd1, 2'd1, 8'd5, 32'h0000_1234, 1'b0, 1'b0, 1'b0);
        run_case("R5 ror dword", 3'd1, 2'd2, 8'd12, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_ring();
        run_case("R6 rcl byte wrap", 3'd2, 2'd0, 8'd20, 32'h0000_00A5, 1'b1, 1'b0, 1'b0);
        run_case("R6 rcl byte 9", 3'd2, 2'd0, 8'd9, 32'h0000_003C, 1'b1, 1'b0, 1'b0);
        run_case("R6 rcr word wrap", 3'd3, 2'd1, 8'd19, 32'h0000_8421, 1'b1, 1'b1, 1'b0);
        run_case("R6 rcr dword", 3'd3, 2'd2, 8'd1, 32'h0000_0003, 1'b0, 1'b0, 1'b0);
        run_case("R6 rcl dword 31", 3'd2, 2'd2, 8'd31, 32'h1357_9BDF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_shift();
        run_case("R7 shl byte", 3'd4, 2'd0, 8'd3, 32'h0000_00F1, 1'b0, 1'b0, 1'b0);
        run_case("R7 shl past width", 3'd4, 2'd0, 8'd12, 32'h0000_00FF, 1'b1, 1'b0, 1'b0);
        run_case("R1 op6 shl word", 3'd6, 2'd1, 8'd4, 32'h0000_ABCD, 1'b0, 1'b0, 1'b0);
        run_case("R7 shr word", 3'd5, 2'd1, 8'd16, 32'h0000_8001, 1'b0, 1'b0, 1'b0);
        run_case("R7 shr dword", 3'd5, 2'd2, 8'd8, 32'hFF00_0080, 1'b0, 1'b1, 1'b0);
        run_case("R7 sar byte neg", 3'd7, 2'd0, 8'd20, 32'h0000_0080, 1'b0, 1'b0, 1'b0);
        run_case("R7 sar dword", 3'd7, 2'd2, 8'd4, 32'h8000_00F0, 1'b0, 1'b0, 1'b0);
        run_case("R13 size3 dword shl", 3'd4, 2'd3, 8'd1, 32'hC000_0000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_overflow_one();
        run_case("R8 shl count1", 3'd4, 2'd0, 8'd1, 32'h0000_0040, 1'b0, 1'b0, 1'b0);
        run_case("R8 shr count1", 3'd5, 2'd1, 8'd1, 32'h0000_8000, 1'b0, 1'b0, 1'b0);
        run_case("R8 shl count2", 3'd4, 2'd0, 8'd2, 32'h0000_0020, 1'b0, 1'b0, 1'b0);
        run_case("R8 sar count1", 3'd7, 2'd2, 8'd1, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero_count();
        // Set carry=1, zero=1 first; then a zero-count request must not move them.
        run_case("R3 setup", 3'd4, 2'd0, 8'd1, 32'h0000_0080, 1'b0, 1'b0, 1'b0);
        issue(3'd0, 2'd0, 8'd0, 32'h1234_5678, 1'b0, 1'b1, 1'b1);
        chk("R3 result=operand byte", result, 32'h0000_0078);
        chk("R3 flags held", {27'd0, carry_out, ovf_out, zero_out, sign_out, parity_out},
            {27'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
        chk("R3 no valid, done", {30'd0, done, flags_valid}, 32'd2);
        chk("R3 cost zero", 32'(cost), 32'd0);
        issue(3'd5, 2'd1, 8'hE0, 32'h0000_4321, 1'b0, 1'b0, 1'b0);
        chk("R2 high bits ignored result", result, 32'h0000_4321);
        chk("R2 high bits ignored valid", 32'(flags_valid), 32'd0);
        run_case("R2 count 0x21 acts as 1", 3'd4, 2'd1, 8'h21, 32'h0000_4001, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rotate_keeps_zsp();
        run_case("R9 setup zero", 3'd5, 2'd0, 8'd8, 32'h0000_00FF, 1'b0, 1'b0, 1'b0);
        issue(3'd0, 2'd0, 8'd1, 32'h0000_0081, 1'b0, 1'b0, 1'b0);
        chk("R9 rotate keeps zsp", {29'd0, zero_out, sign_out, parity_out},
            {29'd0, 1'b1, 1'b0, 1'b1});
    endtask

    task automatic t_cost();
        run_case("R10 rcl reg", 3'd2, 2'd0, 8'd2, 32'h11, 1'b0, 1'b0, 1'b0);
        run_case("R10 rcr mem", 3'd3, 2'd0, 8'd2, 32'h11, 1'b0, 1'b1, 1'b0);
        run_case("R11 rcl slow", 3'd2, 2'd1, 8'd13, 32'h55AA, 1'b1, 1'b0, 1'b1);
        run_case("R11 rcr slow mem", 3'd3, 2'd2, 8'hFF, 32'h0F0F, 1'b0, 1'b1, 1'b1);
        run_case("R11 rol slow no add", 3'd0, 2'd0, 8'd7, 32'h3C, 1'b0, 1'b1, 1'b1);
        run_case("R11 sar slow no add", 3'd7, 2'd0, 8'd7, 32'h3C, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_done_pulse();
        issue(3'd1, 2'd0, 8'd1, 32'h2, 1'b0, 1'b0, 1'b0);
        chk("R12 done high", 32'(done), 32'd1);
        @(negedge clk);
        chk("R12 done single cycle", {30'd0, done, flags_valid}, 32'd0);
        chk("R13 byte upper zero", {8'd0, result[31:8]}, 32'd0);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_rotate();
        t_ring();
        t_shift();
        t_overflow_one();
        t_zero_count();
        t_rotate_keeps_zsp();
        t_cost();
        t_done_pulse();
        repeat (2) @(negedge clk);
        wrap_up();
    end
endmodule